// File: doc/BRIEF.md
# Reference Clock Loss Guard with Sticky Failover

This block supervises an external reference clock that normally drives the core. A small watchdog counter runs on a local free-running clock. Each rising or falling edge of the reference, brought across by a synchronizer, restarts that counter. When the counter runs out with no edge seen, the reference is declared lost. The core clock then moves to the free-running source through a glitch-free switch, a failure status bit is set, and a one-cycle interrupt request is raised.

The failover is permanent. A reference that starts toggling again does not bring the core back. Only the hardware reset input does that. A configuration bit turns the supervision off. While it is set and no failure has been latched, the core runs from the reference and the free-running oscillator is told to stop to save power. Once a failure is latched, this bit is ignored.

Top module: `refclk_guard`

## Requirements
- R1: While `hw_rst` is high and after it is released, `clk_fail` and `fail_irq` read 0, `osc_en` reads 1 when `cfg_disable` is 0, and `core_clk` equals `ext_clk`.
- R2: After a hardware reset with `cfg_disable` at 0, supervision is active with no further setup. If the disable bit is 0 and `ext_clk` stays still, a loss is reported within 30 `fr_clk` cycles.
- R3: Rising and falling edges of `ext_clk` both restart the watchdog count. If consecutive edges are at most 16 `fr_clk` cycles apart, `clk_fail` never rises.
- R4: If consecutive `ext_clk` edges are 17 or more `fr_clk` cycles apart, or the reference stops, `clk_fail` goes to 1.
- R5: `fail_irq` is high for exactly one `fr_clk` cycle, in the same cycle in which `clk_fail` first reads 1.
- R6: Within 4 `fr_clk` cycles of `clk_fail` rising, `core_clk` equals `fr_clk`. The reference leg is shut off before the free-running leg opens.
- R7: After a failure, edges returning on `ext_clk` change neither `clk_fail` (it stays 1) nor the core clock source (it stays `fr_clk`).
- R8: While `cfg_disable` is 1 and no failure is latched, `core_clk` equals `ext_clk`, `osc_en` is 0, and `clk_fail` stays 0 even if `ext_clk` stops.
- R9: Setting `cfg_disable` to 1 after a failure has no effect. `osc_en` stays 1, `clk_fail` stays 1, and `core_clk` keeps following `fr_clk`.
- R10: A hardware reset after a failure clears `clk_fail` and returns `core_clk` to `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hw_rst | input | 1 | Asynchronous hardware reset, active high |
| ext_clk | input | 1 | External reference clock under supervision |
| fr_clk | input | 1 | Local free-running clock; it clocks the watchdog |
| cfg_disable | input | 1 | Supervision off when 1 (a bit of the system configuration register) |
| core_clk | output | 1 | Clock delivered to the core |
| clk_fail | output | 1 | Reference loss latched; cleared only by reset |
| fail_irq | output | 1 | One `fr_clk`-cycle interrupt request at the moment of detection |
| osc_en | output | 1 | Run enable for the free-running oscillator |

## Verification
On every `fr_clk` cycle the assertions check the following: the interrupt is one cycle long and marks the rise of the failure bit, the failure bit never drops outside reset, the oscillator stays enabled once failed, the two clock legs are never open together, a synchronized edge restarts the count, and a steady disable bit prevents detection. Some behaviour only the bench scenarios can show. The exact 16/17-cycle boundary between tolerated and fatal edge gaps depends on the spacing of the edges. The level of `core_clk` against each source clock before and after failover is measured by sampling. That a returning reference is ignored, and that a hardware reset restores the reference path, also take a full scenario.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;

    localparam int unsigned GUARD_LIMIT_DEF = 16;
    localparam int unsigned EDGE_SYNC_DEF   = 2;
    localparam int unsigned CFG_SYNC_DEF    = 2;
    localparam int unsigned LEG_SYNC_DEF    = 2;

    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_WATCH = 2'd1,
        MON_LOST  = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic lost;
        logic irq;
    } fail_evt_t;

    // true when a count value has reached the last tick before overflow
    function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
        return cnt == (limit - 1);
    endfunction

    // next watchdog count value
    function automatic int unsigned next_count(input int unsigned cnt, input logic restart,
                                               input logic run);
        if (restart || !run) begin
            return 0;
        end
        return cnt + 1;
    endfunction

endpackage

// File: rtl/refclk_guard_edge_sync.sv
module refclk_guard_edge_sync #(
    parameter int unsigned STAGES = refclk_guard_pkg::EDGE_SYNC_DEF
) (
    input  logic fr_clk,
    input  logic hw_rst,
    input  logic ext_clk,
    output logic edge_clr
);
    // STAGES synchronizer flops plus one history flop
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shift_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        shift_q[i] <= 1'b0;
                    end else begin
                        shift_q[i] <= ext_clk;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        shift_q[i] <= 1'b0;
                    end else begin
                        shift_q[i] <= shift_q[i-1];
                    end
                end
            end
        end
    endgenerate

    // either direction of change on the synchronized level
    assign edge_clr = shift_q[DEPTH-1] ^ shift_q[DEPTH-2];

endmodule

// File: rtl/refclk_guard_wdog.sv
module refclk_guard_wdog
    import refclk_guard_pkg::*;
#(
    parameter int unsigned LIMIT    = GUARD_LIMIT_DEF,
    parameter int unsigned CFG_SYNC = CFG_SYNC_DEF,
    localparam int unsigned CW      = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          fr_clk,
    input  logic          hw_rst,
    input  logic          cfg_disable,
    input  logic          edge_clr,
    output logic [CW-1:0] wd_count,
    output mon_state_e    state,
    output fail_evt_t     evt
);
    logic [CFG_SYNC-1:0] dis_q;
    logic                dis_s;
    mon_state_e          state_q;
    mon_state_e          state_d;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       cnt_d;
    logic                irq_q;
    logic                expire;

    // bring the configuration bit into the free-running domain
    generate
        for (genvar i = 0; i < CFG_SYNC; i++) begin : g_cfg
            if (i == 0) begin : g_first
                always_ff @(posedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        dis_q[i] <= 1'b0;
                    end else begin
                        dis_q[i] <= cfg_disable;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        dis_q[i] <= 1'b0;
                    end else begin
                        dis_q[i] <= dis_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign dis_s  = dis_q[CFG_SYNC-1];
    assign expire = (state_q == MON_WATCH) && !edge_clr && at_limit(int'(cnt_q), LIMIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF: begin
                if (!dis_s) begin
                    state_d = MON_WATCH;
                end
            end
            MON_WATCH: begin
                if (dis_s) begin
                    state_d = MON_OFF;
                end else if (expire) begin
                    state_d = MON_LOST;
                end
            end
            MON_LOST: begin
                state_d = MON_LOST;
            end
            default: begin
                state_d = MON_WATCH;
            end
        endcase
    end

    always_comb begin
        cnt_d = CW'(next_count(int'(cnt_q), edge_clr, state_q == MON_WATCH));
    end

    always_ff @(posedge fr_clk or posedge hw_rst) begin
        if (hw_rst) begin
            state_q <= MON_WATCH;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= (state_q == MON_WATCH) && (state_d == MON_LOST);
        end
    end

    assign wd_count = cnt_q;
    assign state    = state_q;
    assign evt.lost = (state_q == MON_LOST);
    assign evt.irq  = irq_q;

endmodule

// File: rtl/refclk_guard_switch.sv
module refclk_guard_switch #(
    parameter int unsigned LEG_SYNC = refclk_guard_pkg::LEG_SYNC_DEF
) (
    input  logic ext_clk,
    input  logic fr_clk,
    input  logic hw_rst,
    input  logic lost,
    output logic ext_en,
    output logic fr_en,
    output logic core_clk
);
    logic                ext_q;
    logic [LEG_SYNC-1:0] fr_q;

    // reference leg: reopened on its own falling edge, shut at once on loss
    // because a dead reference may never produce another edge
    always_ff @(negedge ext_clk or posedge lost) begin
        if (lost) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= 1'b1;
        end
    end

    // free-running leg: opens on its own falling edge once the
    // reference leg is seen closed through a synchronizer
    generate
        for (genvar i = 0; i < LEG_SYNC; i++) begin : g_leg
            if (i == 0) begin : g_first
                always_ff @(negedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        fr_q[i] <= 1'b0;
                    end else begin
                        fr_q[i] <= lost & ~ext_q;
                    end
                end
            end else begin : g_rest
                always_ff @(negedge fr_clk or posedge hw_rst) begin
                    if (hw_rst) begin
                        fr_q[i] <= 1'b0;
                    end else begin
                        fr_q[i] <= fr_q[i-1] & lost;
                    end
                end
            end
        end
    endgenerate

    assign ext_en   = ext_q;
    assign fr_en    = fr_q[LEG_SYNC-1];
    assign core_clk = (ext_clk & ext_q) | (fr_clk & fr_q[LEG_SYNC-1]);

endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
    import refclk_guard_pkg::*;
#(
    parameter int unsigned LIMIT     = GUARD_LIMIT_DEF,
    parameter int unsigned EDGE_SYNC = EDGE_SYNC_DEF,
    parameter int unsigned CFG_SYNC  = CFG_SYNC_DEF,
    parameter int unsigned LEG_SYNC  = LEG_SYNC_DEF
) (
    input  logic hw_rst,
    input  logic ext_clk,
    input  logic fr_clk,
    input  logic cfg_disable,
    output logic core_clk,
    output logic clk_fail,
    output logic fail_irq,
    output logic osc_en
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic          edge_clr;
    logic [CW-1:0] wd_count;
    mon_state_e    mon_state;
    fail_evt_t     evt;
    logic          ext_leg_en;
    logic          fr_leg_en;

    refclk_guard_edge_sync #(
        .STAGES (EDGE_SYNC)
    ) u_edge (
        .fr_clk   (fr_clk),
        .hw_rst   (hw_rst),
        .ext_clk  (ext_clk),
        .edge_clr (edge_clr)
    );

    refclk_guard_wdog #(
        .LIMIT    (LIMIT),
        .CFG_SYNC (CFG_SYNC)
    ) u_wdog (
        .fr_clk      (fr_clk),
        .hw_rst      (hw_rst),
        .cfg_disable (cfg_disable),
        .edge_clr    (edge_clr),
        .wd_count    (wd_count),
        .state       (mon_state),
        .evt         (evt)
    );

    refclk_guard_switch #(
        .LEG_SYNC (LEG_SYNC)
    ) u_switch (
        .ext_clk  (ext_clk),
        .fr_clk   (fr_clk),
        .hw_rst   (hw_rst),
        .lost     (evt.lost),
        .ext_en   (ext_leg_en),
        .fr_en    (fr_leg_en),
        .core_clk (core_clk)
    );

    assign clk_fail = evt.lost;
    assign fail_irq = evt.irq;
    // oscillator may sleep only while supervision is off and nothing has failed
    assign osc_en   = ~cfg_disable | evt.lost;

endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk #(
    parameter int unsigned CW = 4
) (
    input logic          fr_clk,
    input logic          hw_rst,
    input logic          cfg_disable,
    input logic          clk_fail,
    input logic          fail_irq,
    input logic          osc_en,
    input logic          clr_pulse,
    input logic [CW-1:0] wd_count,
    input logic          ext_en,
    input logic          fr_en
);

    AST_CLEAR_RESTARTS: assert property (@(posedge fr_clk) disable iff (hw_rst)
        (clr_pulse && !clk_fail) |=> (wd_count == '0)); // R3

    AST_IRQ_SINGLE: assert property (@(posedge fr_clk) disable iff (hw_rst)
        fail_irq |=> !fail_irq); // R5

    AST_IRQ_MARKS_FAIL: assert property (@(posedge fr_clk) disable iff (hw_rst)
        fail_irq |-> clk_fail); // R5

    AST_FAIL_RAISES_IRQ: assert property (@(posedge fr_clk) disable iff (hw_rst)
        $rose(clk_fail) |-> fail_irq); // R5

    AST_BREAK_BEFORE_MAKE: assert property (@(posedge fr_clk) disable iff (hw_rst)
        fr_en |-> !ext_en); // R6

    AST_FAIL_STICKY: assert property (@(posedge fr_clk) disable iff (hw_rst)
        clk_fail |=> clk_fail); // R7

    AST_DISABLED_QUIET: assert property (@(posedge fr_clk) disable iff (hw_rst)
        (cfg_disable && $past(cfg_disable) && $past(cfg_disable, 2) && !clk_fail)
        |=> !clk_fail); // R8

    AST_OSC_KEPT: assert property (@(posedge fr_clk) disable iff (hw_rst)
        clk_fail |-> osc_en); // R9

endmodule

bind refclk_guard refclk_guard_chk #(
    .CW (CW)
) u_chk (
    .fr_clk      (fr_clk),
    .hw_rst      (hw_rst),
    .cfg_disable (cfg_disable),
    .clk_fail    (clk_fail),
    .fail_irq    (fail_irq),
    .osc_en      (osc_en),
    .clr_pulse   (edge_clr),
    .wd_count    (wd_count),
    .ext_en      (ext_leg_en),
    .fr_en       (fr_leg_en)
);

// File: tb/sim_refclk_guard.sv
module sim_refclk_guard;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int WATCHDOG_CYCLES = 150000;

    // vector table: edge spacing in fr_clk cycles, edge count, expected failure
    localparam int VEC_N = 6;
    localparam int VEC_SPACING [VEC_N] = '{4, 16, 17, 1, 2, 30};
    localparam int VEC_EDGES   [VEC_N] = '{10, 6, 3, 20, 30, 2};
    localparam int VEC_EXPECT  [VEC_N] = '{0, 0, 1, 0, 0, 1};

    logic hw_rst;
    logic ext_clk;
    logic fr_clk;
    logic cfg_disable;
    logic core_clk;
    logic clk_fail;
    logic fail_irq;
    logic osc_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    refclk_guard u0 (
        .hw_rst      (hw_rst),
        .ext_clk     (ext_clk),
        .fr_clk      (fr_clk),
        .cfg_disable (cfg_disable),
        .core_clk    (core_clk),
        .clk_fail    (clk_fail),
        .fail_irq    (fail_irq),
        .osc_en      (osc_en)
    );

    initial fr_clk = 1'b0;
    always #(HALF) fr_clk = ~fr_clk;

    task automatic tick();
        @(posedge fr_clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        hw_rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            ext_clk = ~ext_clk;
        end
        check(clk_fail == 1'b0 && fail_irq == 1'b0, "R1 status held in reset",
              int'({clk_fail, fail_irq}), 0);
        hw_rst = 1'b0;
        tick();
        ext_clk = ~ext_clk;
        tick();
        ext_clk = ~ext_clk;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge fr_clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int irq_seen;
        int irq_at;
        int fail_at;
        hw_rst      = 1'b1;
        ext_clk     = 1'b0;
        cfg_disable = 1'b0;

        // table walk over edge spacings (R3, R4)
        for (int v = 0; v < VEC_N; v++) begin
            do_reset();
            for (int k = 0; k < VEC_EDGES[v]; k++) begin
                repeat (VEC_SPACING[v]) tick();
                ext_clk = ~ext_clk;
            end
            repeat (3) tick();
            check(clk_fail == VEC_EXPECT[v][0],
                  (VEC_EXPECT[v] != 0) ? "R4 wide spacing trips" : "R3 tight spacing tolerated",
                  int'(clk_fail), VEC_EXPECT[v]);
        end

        // R1: state after reset
        do_reset();
        check(clk_fail == 1'b0, "R1 clk_fail after reset", int'(clk_fail), 0);
        check(fail_irq == 1'b0, "R1 fail_irq after reset", int'(fail_irq), 0);
        check(osc_en == 1'b1, "R1 osc_en after reset", int'(osc_en), 1);
        for (int i = 0; i < 6; i++) begin
            tick();
            ext_clk = ~ext_clk;
            #2;
            check(core_clk == ext_clk, "R1 core follows reference", int'(core_clk), int'(ext_clk));
        end

        // R4/R5: stop the reference, watch the interrupt
        irq_seen = 0;
        irq_at   = -1;
        fail_at  = -1;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (fail_irq) begin
                irq_seen++;
                irq_at = i;
            end
            if (clk_fail && fail_at < 0) fail_at = i;
        end
        check(clk_fail == 1'b1, "R4 stopped reference detected", int'(clk_fail), 1);
        check(irq_seen == 1, "R5 interrupt pulse width", irq_seen, 1);
        check(irq_at == fail_at, "R5 interrupt coincides with status", irq_at, fail_at);

        // R6: core now follows fr_clk
        tick();
        check(core_clk == 1'b1, "R6 core high with fr_clk high", int'(core_clk), 1);
        #(HALF);
        check(core_clk == 1'b0, "R6 core low with fr_clk low", int'(core_clk), 0);

        // R7: reference returns, nothing reverts
        for (int i = 0; i < 20; i++) begin
            tick();
            ext_clk = ~ext_clk;
        end
        tick();
        ext_clk = 1'b0;
        check(clk_fail == 1'b1, "R7 status stays set", int'(clk_fail), 1);
        check(core_clk == 1'b1, "R7 core follows fr_clk not reference", int'(core_clk), 1);
        #(HALF);
        ext_clk = 1'b1;
        #1;
        check(core_clk == 1'b0, "R7 core ignores reference high", int'(core_clk), 0);

        // R9: disable after failure has no effect
        cfg_disable = 1'b1;
        repeat (6) tick();
        check(osc_en == 1'b1, "R9 oscillator kept on", int'(osc_en), 1);
        check(clk_fail == 1'b1, "R9 status kept", int'(clk_fail), 1);
        check(core_clk == 1'b1, "R9 core still on fr_clk", int'(core_clk), 1);
        #(HALF);
        check(core_clk == 1'b0, "R9 core low with fr_clk", int'(core_clk), 0);

        // R10: hardware reset restores the reference
        cfg_disable = 1'b0;
        do_reset();
        check(clk_fail == 1'b0, "R10 status cleared", int'(clk_fail), 0);
        tick();
        ext_clk = 1'b0;
        #1;
        check(core_clk == 1'b0, "R10 core low with reference low", int'(core_clk), 0);
        #(HALF);
        ext_clk = 1'b1;
        #1;
        check(core_clk == 1'b1, "R10 core follows reference high", int'(core_clk), 1);

        // R8: supervision off, reference stuck high
        cfg_disable = 1'b1;
        do_reset();
        ext_clk  = 1'b1;
        irq_seen = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (fail_irq) irq_seen++;
        end
        check(clk_fail == 1'b0, "R8 no failure while disabled", int'(clk_fail), 0);
        check(irq_seen == 0, "R8 no interrupt while disabled", irq_seen, 0);
        check(osc_en == 1'b0, "R8 oscillator gated", int'(osc_en), 0);
        #(HALF);
        check(core_clk == 1'b1, "R8 core from reference high", int'(core_clk), 1);
        ext_clk = 1'b0;
        tick();
        check(core_clk == 1'b0, "R8 core from reference low", int'(core_clk), 0);

        // R2: clearing the disable bit arms supervision
        cfg_disable = 1'b0;
        repeat (30) tick();
        check(clk_fail == 1'b1, "R2 armed once enabled", int'(clk_fail), 1);
        check(osc_en == 1'b1, "R2 oscillator on when enabled", int'(osc_en), 1);

        done = 1;
        finish_run();
    end

endmodule